// File: doc/BRIEF.md
# Supply-Drop Interrupt Filter Controller

This block converts the raw output of a supply comparator (high while the supply is at or above the detection threshold) into a non-maskable interrupt request. The comparator level is first brought into the clock domain through a flop chain. It is then sampled at one of four divided rates. A sampled value is accepted as the new filtered level only after consecutive samples agree. Every accepted change of the filtered level is a detection event. An event sets a sticky flag that only software clears. If the flag was clear and interrupts are enabled, the event also produces a one-clock request.

The detector can be switched off. While it is off, the filtered level is held high and the flag is held low. In low-power wait mode the sampling clock is normally stopped. A separate control bit lets the synchronized comparator level drive the filtered level directly, so detection keeps working without the sampling clock. The supply request is merged with the watchdog-underflow and oscillator-failure requests into the single registered interrupt output.

Top module: `supply_drop_nmi_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `det_level_o` is 1, `det_flag_o` is 0 and `nmi_o` is 0.
- R2: `rate_sel_i` selects the sampling period N: 0 gives 2 cycles, 1 gives 4, 2 gives 8 and 3 gives 64. Sampling happens at the clock edges whose count since reset release is a multiple of N. The comparator reaches the sampler through two flops, so an input changed just before edge e is first seen by the sampler at edge e+2.
- R3: The filtered level takes a new value only at the second of two consecutive samples that agree. An input pulse shorter than one sampling period leaves `det_level_o` unchanged and raises no request.
- R4: Each change of `det_level_o` while the detector is enabled sets `det_flag_o` at that edge. If the flag was 0 and interrupts are enabled, `nmi_o` is 1 for exactly the cycle that follows that edge.
- R5: `det_flag_o` stays 1 until `flag_clr_i` is 1 at an edge. If a detection event and a clear meet at the same edge, the flag stays set.
- R6: While `det_flag_o` is 1, a further detection event produces no request, although `det_level_o` still follows the filter.
- R7: With `irq_en_i` 0, a detection event sets the flag but produces no request.
- R8: With `det_en_i` 0, at the next edge `det_level_o` becomes 1 and `det_flag_o` becomes 0, and the filter history is reset to high. When the detector is enabled again, a low comparator level is reported as a new event after two samples.
- R9: With `wait_mode_i` and `wait_path_en_i` both 1, the filter is bypassed. An input change made just before edge e appears on `det_level_o` at edge e+2, with a request under the rules of R4.
- R10: With `wait_mode_i` 1 and `wait_path_en_i` 0, sampling stops and `det_level_o` holds. When wait mode ends, sampling resumes at the next multiple of N.
- R11: `wdt_uflow_i` or `osc_fail_i` high at an edge makes `nmi_o` 1 in the following cycle, whatever the state of the enables and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_ok_i | input | 1 | Raw comparator output, 1 = supply at or above threshold |
| det_en_i | input | 1 | Detector enable; 0 forces the level high and clears the flag |
| irq_en_i | input | 1 | Supply interrupt enable |
| rate_sel_i | input | 2 | Sampling rate code (0: /2, 1: /4, 2: /8, 3: /64) |
| wait_mode_i | input | 1 | Chip is in low-power wait mode |
| wait_path_en_i | input | 1 | Use the unfiltered path during wait mode |
| flag_clr_i | input | 1 | Software write of 0 to the detection flag |
| wdt_uflow_i | input | 1 | Watchdog underflow request |
| osc_fail_i | input | 1 | Oscillator stop or restart request |
| det_level_o | output | 1 | Filtered supply level |
| det_flag_o | output | 1 | Sticky detection flag |
| nmi_o | output | 1 | Merged non-maskable interrupt request |

## Verification
For a comparator change driven just before edge e, the filtered level and the request are due at the edge S1+N. Here S1 is the first multiple of N at or after e+2, or at or after e when the filter resumes from disable or from wait mode. In bypass mode the result is due at e+2. Flag clears and the other interrupt sources take effect one edge after they are applied. The bench counts edges since reset release and computes these edges from the requirements. It then checks level and request on every falling edge of the window, so an early, late or repeated pulse is caught as well as a missing one.

// File: rtl/sdn_pkg.sv
package sdn_pkg;

  // Sampling-rate selector codes
  typedef enum logic [1:0] {
    RATE_DIV2  = 2'd0,
    RATE_DIV4  = 2'd1,
    RATE_DIV8  = 2'd2,
    RATE_SLOW  = 2'd3
  } rate_e;

  localparam int unsigned RATE_CODES  = 4;
  localparam int unsigned HALF_STAGES = 3;

  // log2 of the sampling period for a rate code; the slowest code adds the
  // final divider stage on top of the halving stages
  function automatic int unsigned rate_log2(input int unsigned code,
                                            input int unsigned last_log2);
    if (code < HALF_STAGES) begin
      return code + 1;
    end
    return HALF_STAGES + last_log2;
  endfunction

endpackage

// File: rtl/sdn_sync.sv
module sdn_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sdn_rate_gen.sv
module sdn_rate_gen
  import sdn_pkg::*;
#(
  parameter int unsigned LAST_LOG2 = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  rate_e rate_i,
  output logic  strobe_o
);

  localparam int unsigned CNT_W = HALF_STAGES + LAST_LOG2;

  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      cnt_d;
  logic [RATE_CODES-1:0] tap;

  // free-running divider; it keeps counting while sampling is halted so the
  // sampling phase stays tied to reset release
  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // one tap per rate code: high in the last cycle of each period
  for (genvar k = 0; k < RATE_CODES; k++) begin : g_tap
    localparam int unsigned TAP_LOG2 = rate_log2(k, LAST_LOG2);
    localparam logic [CNT_W-1:0] TAP_MASK = CNT_W'((64'd1 << TAP_LOG2) - 64'd1);
    assign tap[k] = ((cnt_q & TAP_MASK) == TAP_MASK);
  end

  assign strobe_o = run_i & tap[rate_i];

endmodule

// File: rtl/sdn_glitch_filter.sv
module sdn_glitch_filter #(
  parameter int unsigned AGREE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  input  logic bypass_i,
  input  logic smp_i,
  output logic level_o,
  output logic change_o
);

  localparam int unsigned HIST_W = AGREE - 1;

  logic              lvl_q;
  logic              lvl_d;
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;
  logic              agree;

  assign agree = (hist_q == {HIST_W{smp_i}});

  always_comb begin
    lvl_d  = lvl_q;
    hist_d = hist_q;
    if (!en_i) begin
      lvl_d  = 1'b1;
      hist_d = {HIST_W{1'b1}};
    end else if (bypass_i) begin
      lvl_d  = smp_i;
      hist_d = {HIST_W{smp_i}};
    end else if (strobe_i) begin
      hist_d = HIST_W'({hist_q, smp_i});
      if (agree) begin
        lvl_d = smp_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      hist_q <= {HIST_W{1'b1}};
    end else begin
      lvl_q  <= lvl_d;
      hist_q <= hist_d;
    end
  end

  assign level_o  = lvl_q;
  assign change_o = en_i & (lvl_d != lvl_q);

endmodule

// File: rtl/sdn_flag_irq.sv
module sdn_flag_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic irq_en_i,
  input  logic event_i,
  input  logic clr_i,
  input  logic wdt_i,
  input  logic osc_i,
  output logic flag_o,
  output logic nmi_o
);

  logic flag_q;
  logic flag_d;
  logic nmi_q;
  logic nmi_d;
  logic supply_req;

  // a request only on an event that finds the flag still clear
  assign supply_req = event_i & irq_en_i & ~flag_q;

  always_comb begin
    flag_d = flag_q;
    if (!en_i) begin
      flag_d = 1'b0;
    end else if (event_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
    nmi_d = supply_req | wdt_i | osc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      nmi_q  <= nmi_d;
    end
  end

  assign flag_o = flag_q;
  assign nmi_o  = nmi_q;

endmodule

// File: rtl/supply_drop_nmi_ctrl.sv
module supply_drop_nmi_ctrl
  import sdn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned AGREE_SAMPLES = 2,
  parameter int unsigned LAST_DIV_LOG2 = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmp_ok_i,
  input  logic       det_en_i,
  input  logic       irq_en_i,
  input  logic [1:0] rate_sel_i,
  input  logic       wait_mode_i,
  input  logic       wait_path_en_i,
  input  logic       flag_clr_i,
  input  logic       wdt_uflow_i,
  input  logic       osc_fail_i,
  output logic       det_level_o,
  output logic       det_flag_o,
  output logic       nmi_o
);

  rate_e rate_sel;
  logic  cmp_sync;
  logic  smp_run;
  logic  smp_strobe;
  logic  bypass;
  logic  level_change;

  assign rate_sel = rate_e'(rate_sel_i);
  assign bypass   = wait_mode_i & wait_path_en_i;
  assign smp_run  = ~(wait_mode_i & ~wait_path_en_i);

  sdn_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_ok_i),
    .q_o    (cmp_sync)
  );

  sdn_rate_gen #(
    .LAST_LOG2 (LAST_DIV_LOG2)
  ) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (smp_run),
    .rate_i   (rate_sel),
    .strobe_o (smp_strobe)
  );

  sdn_glitch_filter #(
    .AGREE (AGREE_SAMPLES)
  ) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (det_en_i),
    .strobe_i (smp_strobe),
    .bypass_i (bypass),
    .smp_i    (cmp_sync),
    .level_o  (det_level_o),
    .change_o (level_change)
  );

  sdn_flag_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (det_en_i),
    .irq_en_i (irq_en_i),
    .event_i  (level_change),
    .clr_i    (flag_clr_i),
    .wdt_i    (wdt_uflow_i),
    .osc_i    (osc_fail_i),
    .flag_o   (det_flag_o),
    .nmi_o    (nmi_o)
  );

endmodule

// File: rtl/sdn_nmi_checker.sv
module sdn_nmi_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic det_en_i,
  input logic irq_en_i,
  input logic wait_mode_i,
  input logic wait_path_en_i,
  input logic flag_clr_i,
  input logic wdt_uflow_i,
  input logic osc_fail_i,
  input logic det_level_o,
  input logic det_flag_o,
  input logic nmi_o
);

  // a level change at an enabled edge always leaves the flag set
  p_change_sets_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(det_en_i) && !$stable(det_level_o)) |-> det_flag_o);

  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_flag_o && det_en_i && !flag_clr_i) |=> det_flag_o);

  p_no_repeat_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_flag_o && !wdt_uflow_i && !osc_fail_i) |=> !nmi_o);

  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && !wdt_uflow_i && !osc_fail_i) |=> !nmi_o);

  p_off_clears_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> !det_flag_o);

  p_off_forces_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> det_level_o);

  p_wait_halt_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_mode_i && !wait_path_en_i && det_en_i) |=> $stable(det_level_o));

  p_other_sources_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_uflow_i || osc_fail_i) |=> nmi_o);

endmodule

bind supply_drop_nmi_ctrl sdn_nmi_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .det_en_i       (det_en_i),
  .irq_en_i       (irq_en_i),
  .wait_mode_i    (wait_mode_i),
  .wait_path_en_i (wait_path_en_i),
  .flag_clr_i     (flag_clr_i),
  .wdt_uflow_i    (wdt_uflow_i),
  .osc_fail_i     (osc_fail_i),
  .det_level_o    (det_level_o),
  .det_flag_o     (det_flag_o),
  .nmi_o          (nmi_o)
);

// File: tb/supply_drop_nmi_ctrl_test.sv
`timescale 1ns/1ps
module supply_drop_nmi_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_ok, det_en, irq_en, wait_mode, wait_path_en;
  logic       flag_clr, wdt_uflow, osc_fail;
  logic [1:0] rate_sel;
  logic       det_level, det_flag, nmi;

  int ecnt = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  // edges counted since reset release: edge k is the k-th rising edge after it
  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  supply_drop_nmi_ctrl uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cmp_ok_i       (cmp_ok),
    .det_en_i       (det_en),
    .irq_en_i       (irq_en),
    .rate_sel_i     (rate_sel),
    .wait_mode_i    (wait_mode),
    .wait_path_en_i (wait_path_en),
    .flag_clr_i     (flag_clr),
    .wdt_uflow_i    (wdt_uflow),
    .osc_fail_i     (osc_fail),
    .det_level_o    (det_level),
    .det_flag_o     (det_flag),
    .nmi_o          (nmi)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at edge %0d: actual %0d expected %0d",
               req, what, ecnt, act, exp);
    end
  endtask

  function automatic int period(input int code);
    case (code)
      0:       return 2;
      1:       return 4;
      2:       return 8;
      default: return 64;
    endcase
  endfunction

  // edge at which the second agreeing sample is taken
  function automatic int accept_edge(input int code, input int earliest);
    int n  = period(code);
    int s1 = ((earliest + n - 1) / n) * n;
    return s1 + n;
  endfunction

  // called at a falling edge right after the stimulus; lag is 2 for a new
  // comparator value, 0 when sampling resumes on an already settled value
  task automatic expect_filtered(input int code, input bit old_v, input bit new_v,
                                 input int lag, input bit irq_exp, input string req);
    int s2 = accept_edge(code, ecnt + 1 + lag);
    while (ecnt < s2 + 2) begin
      tick();
      check(det_level == ((ecnt >= s2) ? new_v : old_v), req, "level",
            det_level, (ecnt >= s2) ? new_v : old_v);
      check(nmi == (irq_exp && ecnt == s2), req, "nmi",
            nmi, (irq_exp && ecnt == s2));
    end
    check(det_flag == 1'b1, req, "flag after event", det_flag, 1);
  endtask

  task automatic expect_direct(input bit old_v, input bit new_v, input string req);
    int due = ecnt + 3;
    while (ecnt < due + 2) begin
      tick();
      check(det_level == ((ecnt >= due) ? new_v : old_v), req, "bypass level",
            det_level, (ecnt >= due) ? new_v : old_v);
      check(nmi == (ecnt == due), req, "bypass nmi", nmi, (ecnt == due));
    end
  endtask

  task automatic expect_stable(input int cycles, input bit lvl, input string req);
    for (int i = 0; i < cycles; i++) begin
      tick();
      check(det_level == lvl, req, "held level", det_level, lvl);
      check(nmi == 1'b0, req, "no nmi", nmi, 0);
    end
  endtask

  task automatic clear_flag(input string req);
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    check(det_flag == 1'b0, req, "flag cleared", det_flag, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    check(det_level == 1'b1, "R1", "level in reset", det_level, 1);
    check(det_flag == 1'b0, "R1", "flag in reset", det_flag, 0);
    check(nmi == 1'b0, "R1", "nmi in reset", nmi, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check(det_level == 1'b1 && det_flag == 1'b0 && nmi == 1'b0, "R1",
          "state after release", {det_level, det_flag, nmi}, 3'b100);
  endtask

  task automatic t_rates();
    for (int code = 0; code < 4; code++) begin
      rate_sel = 2'(code);
      cmp_ok = 1'b0;
      expect_filtered(code, 1'b1, 1'b0, 2, 1'b1, "R2");
      clear_flag("R5");
      cmp_ok = 1'b1;
      expect_filtered(code, 1'b0, 1'b1, 2, 1'b1, "R2");
      clear_flag("R5");
    end
  endtask

  task automatic t_glitch();
    rate_sel = 2'd1;
    cmp_ok = 1'b0;
    tick();
    cmp_ok = 1'b1;
    expect_stable(14, 1'b1, "R3");
    check(det_flag == 1'b0, "R3", "flag after glitch", det_flag, 0);
  endtask

  task automatic t_flag_block();
    int s2;
    rate_sel = 2'd0;
    cmp_ok = 1'b0;
    expect_filtered(0, 1'b1, 1'b0, 2, 1'b1, "R4");
    cmp_ok = 1'b1;
    expect_filtered(0, 1'b0, 1'b1, 2, 1'b0, "R6");
    repeat (3) tick();
    check(det_flag == 1'b1, "R5", "flag sticky", det_flag, 1);
    clear_flag("R5");
    // clear and event at the same edge: the event wins
    cmp_ok = 1'b0;
    s2 = accept_edge(0, ecnt + 3);
    while (ecnt < s2 - 1) tick();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    check(det_flag == 1'b1, "R5", "set beats clear", det_flag, 1);
    check(nmi == 1'b1, "R5", "nmi with clear", nmi, 1);
    clear_flag("R5");
    cmp_ok = 1'b1;
    expect_filtered(0, 1'b0, 1'b1, 2, 1'b1, "R4");
    clear_flag("R5");
  endtask

  task automatic t_irq_gate();
    irq_en = 1'b0;
    cmp_ok = 1'b0;
    expect_filtered(0, 1'b1, 1'b0, 2, 1'b0, "R7");
    irq_en = 1'b1;
    clear_flag("R7");
    cmp_ok = 1'b1;
    expect_filtered(0, 1'b0, 1'b1, 2, 1'b1, "R7");
    clear_flag("R7");
  endtask

  task automatic t_disable();
    rate_sel = 2'd1;
    cmp_ok = 1'b0;
    expect_filtered(1, 1'b1, 1'b0, 2, 1'b1, "R8");
    det_en = 1'b0;
    tick();
    check(det_level == 1'b1, "R8", "forced level", det_level, 1);
    check(det_flag == 1'b0, "R8", "flag cleared by disable", det_flag, 0);
    check(nmi == 1'b0, "R8", "no nmi on disable", nmi, 0);
    expect_stable(8, 1'b1, "R8");
    det_en = 1'b1;
    expect_filtered(1, 1'b1, 1'b0, 0, 1'b1, "R8");
    clear_flag("R8");
    cmp_ok = 1'b1;
    expect_filtered(1, 1'b0, 1'b1, 2, 1'b1, "R8");
    clear_flag("R8");
  endtask

  task automatic t_wait_bypass();
    rate_sel = 2'd3;
    wait_mode = 1'b1;
    wait_path_en = 1'b1;
    cmp_ok = 1'b0;
    expect_direct(1'b1, 1'b0, "R9");
    clear_flag("R9");
    cmp_ok = 1'b1;
    expect_direct(1'b0, 1'b1, "R9");
    clear_flag("R9");
    wait_mode = 1'b0;
    wait_path_en = 1'b0;
  endtask

  task automatic t_wait_halt();
    rate_sel = 2'd0;
    wait_mode = 1'b1;
    wait_path_en = 1'b0;
    cmp_ok = 1'b0;
    expect_stable(16, 1'b1, "R10");
    wait_mode = 1'b0;
    expect_filtered(0, 1'b1, 1'b0, 0, 1'b1, "R10");
    clear_flag("R10");
    cmp_ok = 1'b1;
    expect_filtered(0, 1'b0, 1'b1, 2, 1'b1, "R10");
    clear_flag("R10");
  endtask

  task automatic t_other_sources();
    irq_en = 1'b0;
    wdt_uflow = 1'b1;
    tick();
    wdt_uflow = 1'b0;
    check(nmi == 1'b1, "R11", "watchdog nmi", nmi, 1);
    tick();
    check(nmi == 1'b0, "R11", "watchdog nmi ends", nmi, 0);
    osc_fail = 1'b1;
    tick();
    osc_fail = 1'b0;
    check(nmi == 1'b1, "R11", "oscillator nmi", nmi, 1);
    tick();
    check(nmi == 1'b0 && det_level == 1'b1, "R11", "nmi ends, level kept",
          {nmi, det_level}, 2'b01);
    irq_en = 1'b1;
  endtask

  initial begin
    cmp_ok = 1'b1; det_en = 1'b1; irq_en = 1'b1; rate_sel = 2'd0;
    wait_mode = 1'b0; wait_path_en = 1'b0; flag_clr = 1'b0;
    wdt_uflow = 1'b0; osc_fail = 1'b0;
    t_reset();
    t_rates();
    t_glitch();
    t_flag_block();
    t_irq_gate();
    t_disable();
    t_wait_bypass();
    t_wait_halt();
    t_other_sources();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual %0d expected done", ecnt);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule